// File: doc/BRIEF.md
# Twin-Register Stage Guard

This block sits at one boundary of a duplicated pipeline. It holds a main stage register and a shadow stage register. Each register has a two-input routing multiplexer in front of it. A comparator looks at the two registered values one cycle after they were written. The two copies of the combinational stage logic are modelled as inputs. The late, skewed sample of the main logic is also an input, with its own strobe. The block then turns a disagreement into a stall with correction, or into a flush request, depending on the operating mode.

There are three operating modes. In lockstep, each logic copy feeds its own register, and a mismatch requests a flush and replay. If the same instruction mismatches again right after its replay, the shadow value is accepted instead. In timing-speculation mode, only the shadow register is used on the shadow side. It captures the main logic result a skew later. A mismatch stalls for one cycle while the late value overwrites the main register, and the stage then resumes. In shared mode, one surviving logic copy feeds both registers to mask a broken unit. This mode is honoured only when the two pipelines run without clock skew.

Top module: `twin_stage_guard`

## Requirements
- R1: Under reset (rst_n low at a clock edge) both registers and the held tag clear to zero, and err_o, stall_o and flush_o are low. in_ready_o is high.
- R2: The registers change only on an accepted transfer (in_valid_i and in_ready_o high) or on a correction. The main register is written only when main_en_i is high, and the shadow register only when shad_en_i is high.
- R3: mode_i selects the routing. With 0 (lockstep), the main register takes main_logic_i and the shadow register takes shad_logic_i. With 1 (timing), the main register takes main_logic_i and the shadow register takes late_data_i, but only when late_valid_i is also high. With 2 (shared), both registers take main_logic_i when share_src_i is 0 and shad_logic_i when it is 1. Mode 3 behaves as lockstep.
- R4: With mode 2 and skew_zero_i low, cfg_err_o is high and routing and error handling fall back to lockstep.
- R5: err_o rises in the cycle after an accepted transfer that wrote both registers with different values while chk_en_i is high. A transfer that wrote only one register is never compared.
- R6: A timing-mode mismatch raises stall_o, drops in_ready_o and keeps flush_o low. At the next edge the shadow value is copied into the main register, and in the following cycle stall_o is low and in_ready_o is high.
- R7: A lockstep mismatch on a tag other than the recorded one raises flush_o and drops in_ready_o. At the next edge the tag is recorded and the item is discarded, so no error follows for it.
- R8: A lockstep mismatch on the recorded tag gives no flush. It raises stall_o and copies the shadow value into the main register at the next edge.
- R9: Any clean comparison forgets the recorded tag, so a later mismatch on that tag flushes again.
- R10: With chk_en_i low, differing register values raise none of err_o, stall_o or flush_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 lockstep, 1 timing speculation, 2 shared, 3 as lockstep |
| skew_zero_i | input | 1 | Both pipelines run with no clock skew |
| share_src_i | input | 1 | Surviving logic copy in shared mode (0 main, 1 shadow) |
| chk_en_i | input | 1 | Comparator enable |
| main_en_i | input | 1 | Main register enable |
| shad_en_i | input | 1 | Shadow register enable |
| in_valid_i | input | 1 | Upstream item valid |
| in_ready_o | output | 1 | Stage accepts an item |
| in_tag_i | input | TAG_W | Instruction tag of the incoming item |
| main_logic_i | input | DATA_W | Result of the main logic copy |
| shad_logic_i | input | DATA_W | Result of the shadow logic copy |
| late_valid_i | input | 1 | Late sample of the main result is present |
| late_data_i | input | DATA_W | Main result sampled after the skew |
| stage_q_o | output | DATA_W | Main register (corrected value) |
| shadow_q_o | output | DATA_W | Shadow register |
| tag_o | output | TAG_W | Tag of the held item |
| err_o | output | 1 | Register pair disagrees |
| stall_o | output | 1 | Stall while the main register is corrected |
| flush_o | output | 1 | Flush and replay request |
| cfg_err_o | output | 1 | Shared mode requested with skew present |

## Verification
The compare path is exercised with equal pairs, with differing pairs in each mode, and with pairs where only one register was written. This separates a true mismatch from stale register contents. Lockstep sequences of mismatch, flush, replay and second mismatch on the same tag show whether recurrence leads to acceptance rather than a second flush. Placing a clean comparison between two mismatches on one tag shows whether the recorded tag is forgotten. Timing-mode pairs, where the late value differs from the early one, check that the late value ends up in the main register after one stall cycle. Shared mode is tried with each surviving copy and with skew present, which shows source selection and the fallback.

// File: rtl/twin_stage_pkg.sv
// Shared mode encoding for the twin-register stage guard.
// Assumes a 2-bit mode field; code 3 is folded onto lockstep by the top.
package twin_stage_pkg;
    typedef enum logic [1:0] {
        GM_LOCK  = 2'd0,
        GM_SPEC  = 2'd1,
        GM_SHARE = 2'd2,
        GM_RSVD  = 2'd3
    } guard_mode_e;
endpackage

// File: rtl/tsg_route_mux.sv
// Two-way routing multiplexer in front of a stage register.
// Assumes both candidates are settled before the capturing edge.
module tsg_route_mux #(
    parameter int DATA_W = 16
) (
    input  logic              pick_b_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);
    // select one of the two logic copies
    always_comb y_o = pick_b_i ? b_i : a_i;
endmodule

// File: rtl/tsg_pair_compare.sv
// Compares the registered main/shadow pair in lanes, one cycle after capture.
// Assumes both inputs come straight from registers (keeps it off the stage path).
module tsg_pair_compare #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 4
) (
    input  logic              armed_i,
    input  logic [DATA_W-1:0] main_q_i,
    input  logic [DATA_W-1:0] shad_q_i,
    output logic              mismatch_o,
    output logic              clean_o
);
    localparam int LANES = (DATA_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] a_pad, b_pad;
    logic [LANES-1:0] lane_diff;

    // zero-extend both words to whole lanes
    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[DATA_W-1:0] = main_q_i;
        b_pad[DATA_W-1:0] = shad_q_i;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // per-lane inequality
        always_comb lane_diff[l] = |(a_pad[l*LANE_W +: LANE_W] ^ b_pad[l*LANE_W +: LANE_W]);
    end

    // combine lanes into verdicts
    always_comb begin
        mismatch_o = armed_i && (|lane_diff);
        clean_o    = armed_i && !(|lane_diff);
    end
endmodule

// File: rtl/tsg_replay_tracker.sv
// Remembers the tag of the last flushed item so a repeat mismatch can be accepted.
// Assumes flush and clean are never asserted together.
module tsg_replay_tracker #(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             clean_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             trust_o
);
    logic [TAG_W-1:0] last_tag;
    logic             last_vld;

    // record on flush, forget on clean compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_tag <= '0;
            last_vld <= 1'b0;
        end else if (flush_i) begin
            last_tag <= tag_i;
            last_vld <= 1'b1;
        end else if (clean_i) begin
            last_vld <= 1'b0;
        end
    end

    // the held item is a replay of the flushed one
    always_comb trust_o = last_vld && (last_tag == tag_i);
endmodule

// File: rtl/twin_stage_guard.sv
// Main/shadow register pair with routing, delayed compare and mode-specific recovery.
// Assumes stage logic copies, skewed sampling and power gating are modelled by the inputs.
module twin_stage_guard
    import twin_stage_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4,
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              skew_zero_i,
    input  logic              share_src_i,
    input  logic              chk_en_i,
    input  logic              main_en_i,
    input  logic              shad_en_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [TAG_W-1:0]  in_tag_i,
    input  logic [DATA_W-1:0] main_logic_i,
    input  logic [DATA_W-1:0] shad_logic_i,
    input  logic              late_valid_i,
    input  logic [DATA_W-1:0] late_data_i,
    output logic [DATA_W-1:0] stage_q_o,
    output logic [DATA_W-1:0] shadow_q_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              err_o,
    output logic              stall_o,
    output logic              flush_o,
    output logic              cfg_err_o
);
    guard_mode_e              eff_mode;
    logic [DATA_W-1:0]        main_next, shad_next, main_path;
    logic                     main_pick_shad, shad_pick_own;
    logic [DATA_W-1:0]        main_q, shad_q;
    logic [TAG_W-1:0]         tag_q;
    logic                     fresh_q;
    logic                     fire, shad_cap;
    logic                     mismatch, clean, trust;
    logic                     spec_fix, lock_miss, accept, flush_req;

    // fold reserved code and unsafe shared request onto lockstep
    always_comb begin
        cfg_err_o = (guard_mode_e'(mode_i) == GM_SHARE) && !skew_zero_i;
        case (guard_mode_e'(mode_i))
            GM_SPEC:  eff_mode = GM_SPEC;
            GM_SHARE: eff_mode = skew_zero_i ? GM_SHARE : GM_LOCK;
            default:  eff_mode = GM_LOCK;
        endcase
    end

    // routing selects for both registers
    always_comb begin
        main_pick_shad = (eff_mode == GM_SHARE) && share_src_i;
        shad_pick_own  = (eff_mode == GM_LOCK) || ((eff_mode == GM_SHARE) && share_src_i);
        main_path      = (eff_mode == GM_SPEC) ? late_data_i : main_logic_i;
    end

    tsg_route_mux #(.DATA_W(DATA_W)) u_main_mux (
        .pick_b_i (main_pick_shad),
        .a_i      (main_logic_i),
        .b_i      (shad_logic_i),
        .y_o      (main_next)
    );

    tsg_route_mux #(.DATA_W(DATA_W)) u_shad_mux (
        .pick_b_i (shad_pick_own),
        .a_i      (main_path),
        .b_i      (shad_logic_i),
        .y_o      (shad_next)
    );

    tsg_pair_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
        .armed_i    (fresh_q && chk_en_i),
        .main_q_i   (main_q),
        .shad_q_i   (shad_q),
        .mismatch_o (mismatch),
        .clean_o    (clean)
    );

    tsg_replay_tracker #(.TAG_W(TAG_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush_req),
        .clean_i (clean),
        .tag_i   (tag_q),
        .trust_o (trust)
    );

    // recovery decision by mode
    always_comb begin
        spec_fix  = mismatch && (eff_mode == GM_SPEC);
        lock_miss = mismatch && (eff_mode != GM_SPEC);
        accept    = lock_miss && trust;
        flush_req = lock_miss && !trust;
        stall_o   = spec_fix || accept;
        flush_o   = flush_req;
        err_o     = mismatch;
        in_ready_o = !(stall_o || flush_req);
        fire      = in_valid_i && in_ready_o;
        shad_cap  = shad_en_i && ((eff_mode != GM_SPEC) || late_valid_i);
    end

    // register pair, tag and compare-pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q  <= '0;
            shad_q  <= '0;
            tag_q   <= '0;
            fresh_q <= 1'b0;
        end else if (stall_o) begin
            main_q  <= shad_q;
        end else if (flush_req) begin
            fresh_q <= 1'b0;
        end else if (fire) begin
            if (main_en_i) main_q <= main_next;
            if (shad_cap)  shad_q <= shad_next;
            tag_q   <= in_tag_i;
            fresh_q <= main_en_i && shad_cap;
        end else begin
            fresh_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        stage_q_o  = main_q;
        shadow_q_o = shad_q;
        tag_o      = tag_q;
    end
endmodule

// File: rtl/tsg_checker.sv
// Temporal properties of the stage guard, observed at its ports.
// Assumes it is attached by the bind below.
module tsg_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid_i,
    input logic              in_ready_o,
    input logic [DATA_W-1:0] stage_q_o,
    input logic [DATA_W-1:0] shadow_q_o,
    input logic              err_o,
    input logic              stall_o,
    input logic              flush_o
);
    // R6
    stall_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (stage_q_o == $past(shadow_q_o)));

    // R6
    stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    // R7
    flush_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!err_o && !flush_o));

    // R5
    err_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(in_valid_i && in_ready_o));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid_i && in_ready_o) && !stall_o) |=> ($stable(stage_q_o) && $stable(shadow_q_o)));
endmodule

bind twin_stage_guard tsg_checker #(.DATA_W(DATA_W)) u_tsg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .stage_q_o  (stage_q_o),
    .shadow_q_o (shadow_q_o),
    .err_o      (err_o),
    .stall_o    (stall_o),
    .flush_o    (flush_o)
);

// File: tb/twin_stage_guard_bench.sv
module twin_stage_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_i;
    logic        skew_zero_i, share_src_i, chk_en_i, main_en_i, shad_en_i;
    logic        in_valid_i, in_ready_o, late_valid_i;
    logic [3:0]  in_tag_i, tag_o;
    logic [15:0] main_logic_i, shad_logic_i, late_data_i, stage_q_o, shadow_q_o;
    logic        err_o, stall_o, flush_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    twin_stage_guard u_twin_stage_guard (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .skew_zero_i(skew_zero_i),
        .share_src_i(share_src_i), .chk_en_i(chk_en_i), .main_en_i(main_en_i),
        .shad_en_i(shad_en_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .in_tag_i(in_tag_i), .main_logic_i(main_logic_i), .shad_logic_i(shad_logic_i),
        .late_valid_i(late_valid_i), .late_data_i(late_data_i), .stage_q_o(stage_q_o),
        .shadow_q_o(shadow_q_o), .tag_o(tag_o), .err_o(err_o), .stall_o(stall_o),
        .flush_o(flush_o), .cfg_err_o(cfg_err_o)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        chk, men, sen, skz, src, v, lv;
        logic [3:0]  tag;
        logic [15:0] md, sd, ld;
        logic        e_err, e_stall, e_flush, e_rdy, e_cfg;
        logic [15:0] e_sq, e_hq;
    } vec_t;

    localparam int NV = 20;
    // each row: drive for one cycle, then outputs after the edge must match
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd1,16'h1111,16'h1111,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h1111,16'h1111}, // R3 R5 equal pair
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd2,16'h2222,16'h2A2A,16'h0000, 1'b1,1'b0,1'b1,1'b0,1'b0,16'h2222,16'h2A2A}, // R7 flush request
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd3,16'h3333,16'h3333,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h2222,16'h2A2A}, // R7 discard, R2 no capture
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd2,16'h2222,16'h2A2A,16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,16'h2222,16'h2A2A}, // R8 replay mismatch
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h2A2A,16'h2A2A}, // R8 shadow accepted
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h2A2A,16'h2A2A}, // R2 idle hold
        '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd4,16'h4444,16'hDEAD,16'h4448, 1'b1,1'b1,1'b0,1'b0,1'b0,16'h4444,16'h4448}, // R3 R6 timing mismatch
        '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd5,16'h5555,16'h0000,16'h5555, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h4448,16'h4448}, // R6 corrected, resumes
        '{2'd1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd5,16'h5555,16'h0000,16'h9999, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h5555,16'h4448}, // R3 R5 no late strobe
        '{2'd2,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,4'd6,16'h6666,16'h7777,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h7777,16'h7777}, // R3 shared, shadow copy
        '{2'd2,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd6,16'h8888,16'h7777,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h8888,16'h8888}, // R3 shared, main copy
        '{2'd2,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd7,16'h9999,16'h9A9A,16'h0000, 1'b1,1'b0,1'b1,1'b0,1'b1,16'h9999,16'h9A9A}, // R4 skew fallback
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h9999,16'h9A9A}, // R7 flush taken
        '{2'd0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd8,16'hAAAA,16'hBBBB,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'hAAAA,16'hBBBB}, // R10 checker off
        '{2'd0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,4'd9,16'hCCCC,16'hCCCC,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'hAAAA,16'hCCCC}, // R2 main enable off
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd1,16'h1234,16'h1234,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h1234,16'h1234}, // R9 clean compare
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd7,16'h5A5A,16'hA5A5,16'h0000, 1'b1,1'b0,1'b1,1'b0,1'b0,16'h5A5A,16'hA5A5}, // R9 tag forgotten, flush again
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h5A5A,16'hA5A5}, // R7 flush taken
        '{2'd3,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd2,16'h0F0F,16'hF0F0,16'h0000, 1'b1,1'b0,1'b1,1'b0,1'b0,16'h0F0F,16'hF0F0}, // R3 code 3 as lockstep
        '{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,4'd0,16'h0000,16'h0000,16'h0000, 1'b0,1'b0,1'b0,1'b1,1'b0,16'h0F0F,16'hF0F0}  // R7 flush taken
    };

    task automatic drive(input vec_t t);
        mode_i = t.mode; chk_en_i = t.chk; main_en_i = t.men; shad_en_i = t.sen;
        skew_zero_i = t.skz; share_src_i = t.src; in_valid_i = t.v; late_valid_i = t.lv;
        in_tag_i = t.tag; main_logic_i = t.md; shad_logic_i = t.sd; late_data_i = t.ld;
    endtask

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [36:0] observe();
        return {err_o, stall_o, flush_o, in_ready_o, cfg_err_o, stage_q_o, shadow_q_o};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive('{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,4'd5,16'hFFFF,16'h1234,16'h4321,
                1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000});
        repeat (3) @(negedge clk);
        // R1 reset state holds even with traffic offered
        check("R1 reset", observe(), {1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h0000});
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("vector %0d (see row tag)", i), observe(),
                  {VECS[i].e_err, VECS[i].e_stall, VECS[i].e_flush, VECS[i].e_rdy,
                   VECS[i].e_cfg, VECS[i].e_sq, VECS[i].e_hq});
        end
        // R8 again in timing mode is not needed; R1 mid-run reset after a mismatch
        drive('{2'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,4'd3,16'h1111,16'h2222,16'h0000,
                1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000});
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", observe(), {1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'h0000});
        checks++;
        if (tag_o !== 4'd0) begin
            errors++;
            $display("FAIL R1 tag actual=%h expected=0", tag_o);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule